// File: doc/BRIEF.md
# Memory Protection Region Checker

This block guards a processor's memory accesses against a table of software-programmed regions. Software reaches the table through a small register port addressed like auxiliary registers: one global switch, and for every region a base word and a permission-and-size word. A second, purely combinational port takes an access (address, kind of access, privilege mode) and returns allow or deny. It also returns the index of the region that decided the outcome and a flag that is raised when no region covers the address.

Region sizes are powers of two, never below 2 KB. The size is held as a 5-bit exponent code split across two fields of the permission word. Regions may overlap; the valid region with the smallest index always wins. Each region carries six separate permission bits, for read, write and execute in kernel mode and in user mode. A valid region with no permission bit set turns its span into a no-access guard area, for example below a thread's stack.

Top module: `mpu_region_checker`

## Requirements
- R1: After reset the checker is disabled and every region is invalid. The switch register and all region registers read back as zero, and every access is allowed.
- R2: Writing register 0x409 sets the checker's enable from data bit 30; other data bits are dropped. A read of 0x409 returns bit 30 as the enable and zero elsewhere.
- R3: Region i's base word is at 0x422+2*i and its permission word is at 0x423+2*i. A base word keeps bits [31:11] (address) and bit 0 (valid) and reads back zero in bits [10:1]. A permission word keeps bits [11:3] and [1:0] and reads back zero in bit 2 and bits [31:12].
- R4: Register 0x06D is read-only and reports the number of regions in bits [15:8], with zero in all other bits. Writes to it change nothing. Every unmapped address reads as zero.
- R5: The size code is {perm[11:9], perm[1:0]} and means log2(size)-1. A code below 10 is treated as 10, the 2 KB minimum. Code 31 covers the whole 4 GB space.
- R6: A region matches when it is valid and the access address equals its base in every bit at or above log2(size). Invalid regions never match.
- R7: When several regions match, the lowest index decides the outcome, and that index is reported.
- R8: Permission bits in the winning region's word: user execute bit 3, user write bit 4, user read bit 5, kernel execute bit 6, kernel write bit 7, kernel read bit 8. Access kind encoding is 0 read, 1 write, 2 execute. Mode input 1 means user and 0 means kernel.
- R9: A matching region with all six permission bits clear denies every access to its span.
- R10: While disabled, every access is allowed, the no-match flag is low and the index output is zero.
- R11: While enabled, an access that no valid region matches is denied, raises the no-match flag and reports index zero.
- R12: A register write changes state at the next rising clock edge. The check output follows the current state combinationally.
- R13: Access kind 3 is reserved and is denied whenever a region matches while the checker is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational on reg_addr |
| acc_addr | input | 32 | Address of the access to check |
| acc_kind | input | 2 | 0 read, 1 write, 2 execute, 3 reserved |
| acc_user | input | 1 | 1 user mode, 0 kernel mode |
| acc_allow | output | 1 | Access permitted |
| acc_hit_idx | output | 4 | Index of the deciding region |
| acc_no_match | output | 1 | Enabled and no valid region matched |

## Verification
On every cycle the assertions check that a disabled checker allows everything, that a no-match result is a denial with index zero, that at most one region wins, and that a guard region denies. They also check that the enable register follows its bit-30 write and holds without one, and that the size register field stays at its constant. Other behaviours depend on particular programmed layouts, so only the bench's scenarios can show them. These include the size-code split and its 2 KB floor, lowest-index priority between overlapping regions, the mapping from each permission bit to its kind and mode, and the one-edge latency of register writes. A behavioural reference model compares every output on each clock.

// File: rtl/mpu_chk_pkg.sv
package mpu_chk_pkg;

  localparam int REG_W = 32;
  localparam int ADR_W = 12;

  localparam logic [ADR_W-1:0] ADR_SWITCH  = 12'h409;
  localparam logic [ADR_W-1:0] ADR_REGION0 = 12'h422;
  localparam logic [ADR_W-1:0] ADR_SIZEREG = 12'h06D;
  localparam int SWITCH_BIT = 30;

  typedef enum logic [1:0] {
    KIND_READ  = 2'd0,
    KIND_WRITE = 2'd1,
    KIND_EXEC  = 2'd2,
    KIND_RSVD  = 2'd3
  } acc_kind_e;

  // Stored permission/size word, bit order matches the register layout
  typedef struct packed {
    logic [2:0] size_hi;  // [11:9]
    logic       k_rd;     // [8]
    logic       k_wr;     // [7]
    logic       k_ex;     // [6]
    logic       u_rd;     // [5]
    logic       u_wr;     // [4]
    logic       u_ex;     // [3]
    logic [1:0] size_lo;  // [1:0]
  } perm_t;

  function automatic perm_t perm_from_word(logic [REG_W-1:0] w);
    perm_t p;
    p.size_hi = w[11:9];
    p.k_rd    = w[8];
    p.k_wr    = w[7];
    p.k_ex    = w[6];
    p.u_rd    = w[5];
    p.u_wr    = w[4];
    p.u_ex    = w[3];
    p.size_lo = w[1:0];
    return p;
  endfunction

  function automatic logic [REG_W-1:0] perm_to_word(perm_t p);
    return {20'd0, p.size_hi, p.k_rd, p.k_wr, p.k_ex,
            p.u_rd, p.u_wr, p.u_ex, 1'b0, p.size_lo};
  endfunction

  function automatic logic [4:0] size_code(perm_t p);
    return {p.size_hi, p.size_lo};
  endfunction

endpackage

// File: rtl/mpu_regfile.sv
module mpu_regfile
  import mpu_chk_pkg::*;
#(
  parameter int NREG     = 16,
  parameter int MIN_LOG2 = 11,
  parameter int IDX_W    = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      reg_wr,
  input  logic [ADR_W-1:0]          reg_addr,
  input  logic [REG_W-1:0]          reg_wdata,
  output logic [REG_W-1:0]          reg_rdata,
  output logic                      en,
  output logic [NREG-1:0]           valid,
  output logic [REG_W-MIN_LOG2-1:0] base_hi [NREG],
  output perm_t                     perm    [NREG]
);

  localparam int BASE_W  = REG_W - MIN_LOG2;
  localparam int WIN_END = int'(ADR_REGION0) + 2 * NREG;

  logic                 en_q, en_d, en_we;
  logic [ADR_W-1:0]     offs;
  logic                 in_win;
  logic [IDX_W-1:0]     widx;
  logic [NREG-1:0]      base_we, perm_we;
  logic [NREG-1:0]      valid_q;
  logic [BASE_W-1:0]    base_q [NREG];
  perm_t                perm_q [NREG];

  // Address decode
  always_comb begin
    offs   = reg_addr - ADR_REGION0;
    in_win = (int'(reg_addr) >= int'(ADR_REGION0)) && (int'(reg_addr) < WIN_END);
    widx   = offs[IDX_W:1];
    en_we  = reg_wr && (reg_addr == ADR_SWITCH);
    en_d   = reg_wdata[SWITCH_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b0;
    else if (en_we) en_q <= en_d;
  end

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    assign base_we[i] = reg_wr && in_win && !offs[0] && (widx == IDX_W'(i));
    assign perm_we[i] = reg_wr && in_win &&  offs[0] && (widx == IDX_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        valid_q[i] <= 1'b0;
        base_q[i]  <= '0;
      end else if (base_we[i]) begin
        valid_q[i] <= reg_wdata[0];
        base_q[i]  <= reg_wdata[REG_W-1:MIN_LOG2];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) perm_q[i] <= '0;
      else if (perm_we[i]) perm_q[i] <= perm_from_word(reg_wdata);
    end

    assign base_hi[i] = base_q[i];
    assign perm[i]    = perm_q[i];
  end

  // Read-back mux
  always_comb begin
    reg_rdata = '0;
    if (reg_addr == ADR_SWITCH) begin
      reg_rdata[SWITCH_BIT] = en_q;
    end else if (reg_addr == ADR_SIZEREG) begin
      reg_rdata[15:8] = 8'(NREG);
    end else if (in_win) begin
      for (int k = 0; k < NREG; k++) begin
        if (widx == IDX_W'(k)) begin
          if (offs[0]) reg_rdata = perm_to_word(perm_q[k]);
          else         reg_rdata = {base_q[k], {(MIN_LOG2-1){1'b0}}, valid_q[k]};
        end
      end
    end
  end

  assign en    = en_q;
  assign valid = valid_q;

  a_r2_switch_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == ADR_SWITCH) |=> (en == $past(reg_wdata[SWITCH_BIT])));

  a_r12_switch_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_addr == ADR_SWITCH) |=> $stable(en));

  a_r4_size_field: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == ADR_SIZEREG) |-> (reg_rdata[15:8] == 8'(NREG) && reg_rdata[7:0] == 8'd0));

endmodule

// File: rtl/mpu_region_match.sv
module mpu_region_match
  import mpu_chk_pkg::*;
#(
  parameter int MIN_LOG2 = 11
) (
  input  logic                      valid,
  input  logic [REG_W-MIN_LOG2-1:0] base_hi,
  input  logic [4:0]                code,
  input  logic [REG_W-1:0]          addr,
  output logic                      hit
);

  localparam int CMP_W = REG_W - MIN_LOG2;

  logic [5:0]       lg;    // log2 of region size
  logic [CMP_W-1:0] diff;

  assign lg = {1'b0, code} + 6'd1;

  // Bits below MIN_LOG2 never compared; the others only at or above lg
  for (genvar b = MIN_LOG2; b < REG_W; b++) begin : g_bit
    assign diff[b-MIN_LOG2] = (addr[b] ^ base_hi[b-MIN_LOG2]) && (6'(b) >= lg);
  end

  assign hit = valid && (diff == '0);

endmodule

// File: rtl/mpu_first_hit.sv
module mpu_first_hit #(
  parameter int NREG  = 16,
  parameter int IDX_W = 4
) (
  input  logic [NREG-1:0]  hits,
  output logic [NREG-1:0]  grant,
  output logic [IDX_W-1:0] idx,
  output logic             any
);

  always_comb begin
    grant = '0;
    idx   = '0;
    any   = 1'b0;
    for (int i = 0; i < NREG; i++) begin
      if (hits[i] && !any) begin
        grant[i] = 1'b1;
        idx      = IDX_W'(i);
        any      = 1'b1;
      end
    end
  end

endmodule

// File: rtl/mpu_region_checker.sv
module mpu_region_checker
  import mpu_chk_pkg::*;
#(
  parameter int NREG     = 16,
  parameter int MIN_LOG2 = 11,
  parameter int IDX_W    = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [11:0]      reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  logic [31:0]      acc_addr,
  input  logic [1:0]       acc_kind,
  input  logic             acc_user,
  output logic             acc_allow,
  output logic [IDX_W-1:0] acc_hit_idx,
  output logic             acc_no_match
);

  logic [1:0]                rst_pipe;
  logic                      rst_sync_n;
  logic                      en;
  logic [NREG-1:0]           valid;
  logic [REG_W-MIN_LOG2-1:0] base_hi [NREG];
  perm_t                     perm    [NREG];
  logic [NREG-1:0]           hits, grant;
  logic [IDX_W-1:0]          win_idx;
  logic                      any_hit;
  perm_t                     win_perm;
  logic                      perm_ok;

  // Asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  mpu_regfile #(.NREG(NREG), .MIN_LOG2(MIN_LOG2), .IDX_W(IDX_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .en        (en),
    .valid     (valid),
    .base_hi   (base_hi),
    .perm      (perm)
  );

  for (genvar i = 0; i < NREG; i++) begin : g_match
    mpu_region_match #(.MIN_LOG2(MIN_LOG2)) u_match (
      .valid   (valid[i]),
      .base_hi (base_hi[i]),
      .code    (size_code(perm[i])),
      .addr    (acc_addr),
      .hit     (hits[i])
    );
  end

  mpu_first_hit #(.NREG(NREG), .IDX_W(IDX_W)) u_pick (
    .hits  (hits),
    .grant (grant),
    .idx   (win_idx),
    .any   (any_hit)
  );

  // Permission lookup for the winning region
  always_comb begin
    win_perm = '0;
    for (int i = 0; i < NREG; i++) begin
      if (grant[i]) win_perm = perm[i];
    end
    unique case (acc_kind_e'(acc_kind))
      KIND_READ:  perm_ok = acc_user ? win_perm.u_rd : win_perm.k_rd;
      KIND_WRITE: perm_ok = acc_user ? win_perm.u_wr : win_perm.k_wr;
      KIND_EXEC:  perm_ok = acc_user ? win_perm.u_ex : win_perm.k_ex;
      default:    perm_ok = 1'b0;
    endcase
  end

  always_comb begin
    if (!en) begin
      acc_allow    = 1'b1;
      acc_no_match = 1'b0;
      acc_hit_idx  = '0;
    end else begin
      acc_allow    = any_hit && perm_ok;
      acc_no_match = !any_hit;
      acc_hit_idx  = any_hit ? win_idx : '0;
    end
  end

  a_r10_disabled_allows: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !en |-> (acc_allow && !acc_no_match && acc_hit_idx == '0));

  a_r11_no_match_denies: assert property (@(posedge clk) disable iff (!rst_sync_n)
    acc_no_match |-> (!acc_allow && acc_hit_idx == '0));

  a_r7_single_winner: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $onehot0(grant) && (any_hit == (hits != '0)));

  a_r9_guard_denies: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (en && any_hit && perm_to_word(win_perm)[8:3] == 6'd0) |-> !acc_allow);

  a_r13_reserved_kind: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (en && acc_kind == 2'd3) |-> !acc_allow);

endmodule

// File: tb/mpu_region_checker_test.sv
module mpu_region_checker_test;

  localparam int N = 16;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr;
  logic [11:0] reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic [31:0] acc_addr;
  logic [1:0]  acc_kind;
  logic        acc_user;
  logic        acc_allow;
  logic [3:0]  acc_hit_idx;
  logic        acc_no_match;

  int checks = 0;
  int errors = 0;
  bit model_on = 0;

  always #10 clk = ~clk;  // 50 MHz

  mpu_region_checker uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .acc_addr(acc_addr),
    .acc_kind(acc_kind), .acc_user(acc_user), .acc_allow(acc_allow),
    .acc_hit_idx(acc_hit_idx), .acc_no_match(acc_no_match)
  );

  // ---------------- behavioural reference model ----------------
  bit          m_en;
  bit [31:0]   m_base [N];
  bit [31:0]   m_perm [N];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en <= 0;
      for (int i = 0; i < N; i++) begin m_base[i] <= 0; m_perm[i] <= 0; end
    end else if (reg_wr) begin
      if (reg_addr == 12'h409) m_en <= reg_wdata[30];
      else if (reg_addr >= 12'h422 && reg_addr < 12'h422 + 2*N) begin
        int off;
        off = int'(reg_addr) - 'h422;
        if (off % 2 == 0) m_base[off/2] <= reg_wdata & 32'hFFFF_F801;
        else              m_perm[off/2] <= reg_wdata & 32'h0000_0FFB;
      end
    end
  end

  function automatic bit [31:0] m_read(bit [11:0] a);
    if (a == 12'h409) return {1'b0, m_en, 30'd0};
    if (a == 12'h06D) return N << 8;
    if (a >= 12'h422 && a < 12'h422 + 2*N) begin
      int off;
      off = int'(a) - 'h422;
      return (off % 2 == 0) ? m_base[off/2] : m_perm[off/2];
    end
    return 0;
  endfunction

  function automatic void m_access(bit [31:0] a, bit [1:0] kind, bit user,
                                   output bit allow, output int idx, output bit nm);
    allow = 1; idx = 0; nm = 0;
    if (!m_en) return;
    for (int i = 0; i < N; i++) begin
      if (m_base[i][0]) begin
        int lg;
        bit [63:0] x, y;
        lg = {m_perm[i][11:9], m_perm[i][1:0]} + 1;
        if (lg < 11) lg = 11;
        x = {32'd0, a} >> lg;
        y = {32'd0, m_base[i] & 32'hFFFF_FFFE} >> lg;
        if (x == y) begin
          int bitpos;
          idx = i;
          case (kind)
            2'd0: bitpos = user ? 5 : 8;
            2'd1: bitpos = user ? 4 : 7;
            2'd2: bitpos = user ? 3 : 6;
            default: bitpos = -1;
          endcase
          allow = (bitpos >= 0) ? m_perm[i][bitpos] : 1'b0;
          return;
        end
      end
    end
    allow = 0; nm = 1;
  endfunction

  task automatic chk(string req, bit [31:0] act, bit [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  // Every-clock comparison against the model (R12)
  always @(negedge clk) begin
    #2;
    if (model_on) begin
      bit ea; int ei; bit en;
      m_access(acc_addr, acc_kind, acc_user, ea, ei, en);
      chk("R12 model allow", {31'd0, acc_allow}, {31'd0, ea});
      chk("R12 model idx", {28'd0, acc_hit_idx}, 32'(ei));
      chk("R12 model nomatch", {31'd0, acc_no_match}, {31'd0, en});
      chk("R12 model rdata", reg_rdata, m_read(reg_addr));
    end
  end

  // ---------------- stimulus tasks ----------------
  task automatic wr(bit [11:0] a, bit [31:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(bit [11:0] a, output bit [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #3 d = reg_rdata;
  endtask

  task automatic probe(bit [31:0] a, bit [1:0] k, bit u);
    @(negedge clk);
    acc_addr = a; acc_kind = k; acc_user = u;
    #3;
  endtask

  task automatic expect_acc(string req, bit allow, int idx, bit nm);
    chk({req, " allow"}, {31'd0, acc_allow}, {31'd0, allow});
    chk({req, " idx"}, {28'd0, acc_hit_idx}, 32'(idx));
    chk({req, " nomatch"}, {31'd0, acc_no_match}, {31'd0, nm});
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    bit [31:0] d;
    rst_n = 1; reg_wr = 0; reg_addr = 0; reg_wdata = 0;
    acc_addr = 0; acc_kind = 0; acc_user = 0;
    #1 rst_n = 0;
    repeat (3) @(posedge clk);
    #3 rst_n = 1;
    repeat (4) @(posedge clk);
    model_on = 1;

    // R1 reset state
    rd(12'h409, d);  chk("R1 switch after reset", d, 32'h0);
    rd(12'h422, d);  chk("R1 base0 after reset", d, 32'h0);
    rd(12'h441, d);  chk("R1 perm15 after reset", d, 32'h0);
    probe(32'h1234_5678, 2'd1, 1'b1);
    expect_acc("R1 R10 reset allows", 1, 0, 0);

    // R4 size register and unmapped reads
    rd(12'h06D, d);  chk("R4 region count", d, 32'h0000_1000);
    wr(12'h06D, 32'hFFFF_FFFF);
    rd(12'h06D, d);  chk("R4 write ignored", d, 32'h0000_1000);
    rd(12'h500, d);  chk("R4 unmapped reads zero", d, 32'h0);

    // R3 field masking on read-back
    wr(12'h422, 32'h1000_0F7F);
    rd(12'h422, d);  chk("R3 base mask", d, 32'h1000_0801);
    wr(12'h423, 32'hFFFF_FFFF);
    rd(12'h423, d);  chk("R3 perm mask", d, 32'h0000_0FFB);

    // Layout: r0 = 2K guard at 0x10000800, r1 = 64K kernel rw + user r at 0x10000000
    wr(12'h422, 32'h1000_0801);
    wr(12'h423, 32'h0000_0402);
    wr(12'h424, 32'h1000_0001);
    wr(12'h425, 32'h0000_07A3);
    wr(12'h409, 32'hFFFF_FFFF);
    rd(12'h409, d);  chk("R2 switch read-back", d, 32'h4000_0000);

    probe(32'h1000_0900, 2'd0, 1'b0); expect_acc("R9 R7 guard wins", 0, 0, 0);
    probe(32'h1000_1000, 2'd0, 1'b0); expect_acc("R7 R8 kernel read", 1, 1, 0);
    probe(32'h1000_1000, 2'd1, 1'b1); expect_acc("R8 user write denied", 0, 1, 0);
    probe(32'h1000_1000, 2'd0, 1'b1); expect_acc("R8 user read", 1, 1, 0);
    probe(32'h1000_1000, 2'd2, 1'b0); expect_acc("R8 kernel exec denied", 0, 1, 0);
    probe(32'h1000_1000, 2'd3, 1'b0); expect_acc("R13 reserved kind", 0, 1, 0);
    probe(32'h1001_0000, 2'd0, 1'b0); expect_acc("R11 R6 past end", 0, 0, 1);

    // R5 code 0 is raised to the 2K floor
    wr(12'h426, 32'h2000_0001);
    wr(12'h427, 32'h0000_0100);
    probe(32'h2000_07FC, 2'd0, 1'b0); expect_acc("R5 floor inside", 1, 2, 0);
    probe(32'h2000_0800, 2'd0, 1'b0); expect_acc("R5 floor outside", 0, 0, 1);

    // R5 R6 4GB region at index 15 with all permissions
    wr(12'h440, 32'h0000_0001);
    wr(12'h441, 32'h0000_0FFB);
    probe(32'h3000_0000, 2'd2, 1'b1); expect_acc("R5 R6 whole space", 1, 15, 0);
    probe(32'h1000_1000, 2'd2, 1'b0); expect_acc("R7 lower index wins", 0, 1, 0);
    wr(12'h440, 32'h0000_0000);
    probe(32'h3000_0000, 2'd2, 1'b1); expect_acc("R6 invalid ignored", 0, 0, 1);

    // R12 write latency and R10 disabled behaviour
    @(negedge clk);
    reg_wr = 1; reg_addr = 12'h409; reg_wdata = 32'h0;
    #3 chk("R12 before edge", {31'd0, acc_allow}, 32'd0);
    @(posedge clk); #1;
    chk("R12 R10 after edge", {31'd0, acc_allow}, 32'd1);
    @(negedge clk); reg_wr = 0;
    probe(32'h1000_0900, 2'd1, 1'b1); expect_acc("R10 disabled guard", 1, 0, 0);

    repeat (2) @(posedge clk);
    model_on = 0;
    #5;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule